// File: doc/BRIEF.md
# Banked Parallel Dot-Product Engine

This block forms the signed fixed-point dot product of two vectors held in its own on-chip storage. Each operand is spread cyclically over a set of banks, and each bank gives two reads per cycle. As a result, a whole chunk of 32 element pairs leaves storage on every clock. The 32 pairs are multiplied in parallel. A five-level registered adder tree reduces the products to one partial sum per chunk, and that partial sum is added into an accumulator. The accumulator is cleared when a run starts.

Operands are loaded through a single write port before a run. A one-cycle `start_i` pulse with a length `len_i` begins the computation. The engine then takes a new chunk on every cycle until the last one has been issued. The sum is presented on `result_o`, and `done_o` pulses for one cycle when the last partial sum has been accumulated. Lengths that are not whole chunks, or that exceed capacity, are cut down to whole chunks and flagged.

Top module: `dp_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `busy_o`, `done_o` and `len_err_o` at 0 and `result_o` at 0.
- R2: A write with `wr_sel_i`=0 stores element `wr_addr_i` of operand A, and with `wr_sel_i`=1 it stores that element of operand B. Elements are 16-bit two's complement. A run with a length that is a whole number of chunks yields, as a 42-bit signed value, the sum over i < n of A[i]*B[i].
- R3: If `start_i` is sampled at edge E0 with `len_i` >= 32 and the engine is idle, `busy_o` is high from the next cycle. Let N be the number of 32-element chunks. `done_o` is then high for exactly one cycle, right after edge E0+N+7, and `busy_o` falls at that same edge.
- R4: A start with `len_i` < 32 (including 0) raises `done_o` in the cycle after start, with `result_o` equal to 0, and `busy_o` stays low.
- R5: A length that is not a multiple of 32 is truncated to floor(n/32) chunks. A length above 1024 is treated as 32 chunks. In either case `len_err_o` goes high in the cycle after start. A start with a valid length clears `len_err_o`. The flag changes only on an accepted start.
- R6: Each accepted start clears the accumulator, so no previous run's sum carries into the next.
- R7: Writes that arrive while `busy_o` is high leave both operands unchanged.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It does not move the running computation's done cycle or change its result.
- R9: When the engine is idle and no start is given, `result_o` holds its last value.
- R10: The accumulator does not overflow on a full-length run. With all 1024 elements of both operands at -32768, the result is 2^40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Operand write strobe |
| wr_sel_i | input | 1 | Operand select: 0 = A, 1 = B |
| wr_addr_i | input | 10 | Element index to write |
| wr_data_i | input | 16 | Signed element value |
| start_i | input | 1 | One-cycle run request |
| len_i | input | 11 | Vector length for the run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse with final result |
| len_err_o | output | 1 | Length was truncated or clamped |
| result_o | output | 42 | Signed accumulated dot product |

## Verification
On every cycle, the bound assertions check the handshake around a run: busy following an accepted long start, done being a lone pulse that never coincides with busy, an immediate zero result for short lengths, the error flag tracking the length's validity and changing only on a start, and the result holding while idle. The arithmetic itself cannot be checked at that level: which bank and lane carries which element, the exact done cycle N+7 edges after start, the sum clearing between runs, writes and starts being dropped while busy, and the full-scale sum without overflow. These are shown only by the bench's scenarios, which compare each run against a behavioural model of storage and latency.

// File: rtl/dp_pkg.sv
// dp_pkg: shared defaults and the operand-select encoding for the
// dot-product engine. Assumes LANES is a power of two and twice the
// bank count.
package dp_pkg;
    localparam int DATA_W  = 16;
    localparam int LANES   = 32;
    localparam int MAX_LEN = 1024;
    localparam int ACC_W   = 42;

    typedef enum logic {
        OPND_A = 1'b0,
        OPND_B = 1'b1
    } opnd_e;
endpackage

// File: rtl/dp_bank.sv
// dp_bank: one storage bank with one write port and two independent
// registered read ports. Assumes writes and reads of the same row
// never collide in a cycle that matters (writes only while idle).
module dp_bank #(
    parameter int DATA_W = 16,
    parameter int ROWS   = 64,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ROW_W-1:0]  wrow_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ROW_W-1:0]  row_lo_i,
    input  logic [ROW_W-1:0]  row_hi_i,
    output logic [DATA_W-1:0] rd_lo_o,
    output logic [DATA_W-1:0] rd_hi_o
);
    logic [DATA_W-1:0] mem [ROWS];

    // Store one element when selected.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[wrow_i] <= wdata_i;
        end
    end

    // Read both rows every cycle; one cycle of latency.
    always_ff @(posedge clk) begin
        rd_lo_o <= mem[row_lo_i];
        rd_hi_o <= mem[row_hi_i];
    end
endmodule

// File: rtl/dp_lanes_mul.sv
// dp_lanes_mul: LANES parallel signed multipliers with one register
// stage; valid and last markers travel alongside. Assumes inputs are
// two's complement of width DATA_W.
module dp_lanes_mul #(
    parameter int DATA_W  = 16,
    parameter int LANES   = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vld_i,
    input  logic                          last_i,
    input  logic [LANES-1:0][DATA_W-1:0]  a_i,
    input  logic [LANES-1:0][DATA_W-1:0]  b_i,
    output logic                          vld_o,
    output logic                          last_o,
    output logic [LANES-1:0][PROD_W-1:0]  prod_o
);
    logic [LANES-1:0][PROD_W-1:0] prod_d;

    // Form every lane product at full width.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            prod_d[k] = $signed({{DATA_W{a_i[k][DATA_W-1]}}, a_i[k]})
                      * $signed({{DATA_W{b_i[k][DATA_W-1]}}, b_i[k]});
        end
    end

    // Register the products.
    always_ff @(posedge clk) begin
        prod_o <= prod_d;
    end

    // Carry chunk markers with the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            last_o <= 1'b0;
        end else begin
            vld_o  <= vld_i;
            last_o <= last_i;
        end
    end
endmodule

// File: rtl/dp_tree.sv
// dp_tree: registered binary adder tree, one register per level,
// reducing LANES products to a single sum in log2(LANES) cycles.
// Assumes LANES is a power of two; sums grow one bit per level.
module dp_tree #(
    parameter int PROD_W  = 32,
    parameter int LANES   = 32,
    localparam int LVLS   = $clog2(LANES),
    localparam int TREE_W = PROD_W + LVLS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          vld_i,
    input  logic                          last_i,
    input  logic [LANES-1:0][PROD_W-1:0]  prod_i,
    output logic                          vld_o,
    output logic                          last_o,
    output logic signed [TREE_W-1:0]      sum_o
);
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int CNT = LANES >> l;
        logic signed [TREE_W-1:0] sum_q [CNT];
        logic                     vld_q;
        logic                     last_q;

        if (l == 0) begin : g_in
            // Sign-extend the incoming products to tree width.
            always_comb begin
                for (int k = 0; k < CNT; k++) begin
                    sum_q[k] = {{LVLS{prod_i[k][PROD_W-1]}}, prod_i[k]};
                end
            end
            assign vld_q  = vld_i;
            assign last_q = last_i;
        end else begin : g_add
            // Add neighbouring pairs of the level below.
            always_ff @(posedge clk) begin
                for (int k = 0; k < CNT; k++) begin
                    sum_q[k] <= g_lvl[l-1].sum_q[2*k] + g_lvl[l-1].sum_q[2*k+1];
                end
            end
            // Advance the chunk markers one level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q  <= 1'b0;
                    last_q <= 1'b0;
                end else begin
                    vld_q  <= g_lvl[l-1].vld_q;
                    last_q <= g_lvl[l-1].last_q;
                end
            end
        end
    end

    assign sum_o  = g_lvl[LVLS].sum_q[0];
    assign vld_o  = g_lvl[LVLS].vld_q;
    assign last_o = g_lvl[LVLS].last_q;
endmodule

// File: rtl/dp_engine.sv
// dp_engine: banked dot-product engine. Operands are spread cyclically
// over LANES/2 dual-read banks per operand; one chunk of LANES pairs is
// issued per cycle, multiplied, reduced by a tree and accumulated.
// Assumes MAX_LEN is a multiple of LANES and LANES a power of two.
module dp_engine
    import dp_pkg::*;
#(
    parameter int DATA_W     = dp_pkg::DATA_W,
    parameter int LANES      = dp_pkg::LANES,
    parameter int MAX_LEN    = dp_pkg::MAX_LEN,
    parameter int ACC_W      = dp_pkg::ACC_W,
    localparam int ADDR_W    = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              len_err_o,
    output logic [ACC_W-1:0]  result_o
);
    localparam int NUM_BANKS  = LANES / 2;
    localparam int ROWS       = MAX_LEN / NUM_BANKS;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int ROW_W      = $clog2(ROWS);
    localparam int LB         = $clog2(LANES);
    localparam int MAX_CHUNKS = MAX_LEN / LANES;
    localparam int CHUNK_W    = $clog2(MAX_CHUNKS);
    localparam int CNT_W      = $clog2(MAX_CHUNKS + 1);
    localparam int PROD_W     = 2 * DATA_W;
    localparam int TREE_W     = PROD_W + LB;

    logic               busy_q, issue_q, err_q, done_q;
    logic [CHUNK_W-1:0] chunk_q, last_q;
    logic [ACC_W-1:0]   acc_q;
    logic               rd_vld_q, rd_last_q;

    logic [CNT_W-1:0]   req_chunks;
    logic               req_err, accept, over;

    logic [LANES-1:0][DATA_W-1:0] lane_a, lane_b;
    logic [LANES-1:0][PROD_W-1:0] prod;
    logic                         mul_vld, mul_last;
    logic                         tree_vld, tree_last;
    logic signed [TREE_W-1:0]     tree_sum;

    logic [BANK_W-1:0] wr_bank;
    logic [ROW_W-1:0]  wr_row, row_lo, row_hi;
    logic              wr_ok;

    // Decode the requested length into whole chunks and an error flag.
    always_comb begin
        over       = len_i > LEN_W'(MAX_LEN);
        req_err    = over || (len_i[LB-1:0] != '0);
        req_chunks = over ? CNT_W'(MAX_CHUNKS) : CNT_W'(len_i >> LB);
        accept     = start_i && !busy_q;
    end

    // Address split: low bits pick the bank, high bits the row.
    assign wr_bank = wr_addr_i[BANK_W-1:0];
    assign wr_row  = wr_addr_i[ADDR_W-1:BANK_W];
    assign wr_ok   = wr_en_i && !busy_q;
    assign row_lo  = {chunk_q, 1'b0};
    assign row_hi  = {chunk_q, 1'b1};

    for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
        logic hit;
        assign hit = wr_ok && (wr_bank == BANK_W'(bk));

        dp_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank_a (
            .clk      (clk),
            .we_i     (hit && (wr_sel_i == OPND_A)),
            .wrow_i   (wr_row),
            .wdata_i  (wr_data_i),
            .row_lo_i (row_lo),
            .row_hi_i (row_hi),
            .rd_lo_o  (lane_a[bk]),
            .rd_hi_o  (lane_a[bk + NUM_BANKS])
        );

        dp_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank_b (
            .clk      (clk),
            .we_i     (hit && (wr_sel_i == OPND_B)),
            .wrow_i   (wr_row),
            .wdata_i  (wr_data_i),
            .row_lo_i (row_lo),
            .row_hi_i (row_hi),
            .rd_lo_o  (lane_b[bk]),
            .rd_hi_o  (lane_b[bk + NUM_BANKS])
        );
    end

    // Run control: accept a start, step through chunks, end on last sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            issue_q <= 1'b0;
            chunk_q <= '0;
            last_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (issue_q) begin
                chunk_q <= chunk_q + 1'b1;
                if (chunk_q == last_q) begin
                    issue_q <= 1'b0;
                end
            end
            if (tree_vld && tree_last) begin
                busy_q <= 1'b0;
            end
            if (accept) begin
                err_q   <= req_err;
                chunk_q <= '0;
                if (req_chunks != '0) begin
                    busy_q  <= 1'b1;
                    issue_q <= 1'b1;
                    last_q  <= CHUNK_W'(req_chunks - 1'b1);
                end
            end
        end
    end

    // Mark the chunk whose rows the banks are returning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_last_q <= 1'b0;
        end else begin
            rd_vld_q  <= issue_q;
            rd_last_q <= issue_q && (chunk_q == last_q);
        end
    end

    dp_lanes_mul #(.DATA_W(DATA_W), .LANES(LANES)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (rd_vld_q),
        .last_i (rd_last_q),
        .a_i    (lane_a),
        .b_i    (lane_b),
        .vld_o  (mul_vld),
        .last_o (mul_last),
        .prod_o (prod)
    );

    dp_tree #(.PROD_W(PROD_W), .LANES(LANES)) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (mul_vld),
        .last_i (mul_last),
        .prod_i (prod),
        .vld_o  (tree_vld),
        .last_o (tree_last),
        .sum_o  (tree_sum)
    );

    // Accumulate chunk sums, clear on start, flag the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tree_vld) begin
                acc_q <= acc_q + {{(ACC_W-TREE_W){tree_sum[TREE_W-1]}}, tree_sum};
                if (tree_last) begin
                    done_q <= 1'b1;
                end
            end
            if (accept) begin
                acc_q <= '0;
                if (req_chunks == '0) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign len_err_o = err_q;
    assign result_o  = acc_q;
endmodule

// File: rtl/dp_engine_chk.sv
// dp_engine_chk: port-level protocol checks for dp_engine, attached by
// bind. Assumes the same LANES/MAX_LEN/ACC_W as the bound instance.
module dp_engine_chk #(
    parameter int LANES      = 32,
    parameter int MAX_LEN    = 1024,
    parameter int ACC_W      = 42,
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int LB        = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [LEN_W-1:0] len_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             len_err_o,
    input logic [ACC_W-1:0] result_o
);
    logic bad_len;
    assign bad_len = (len_i[LB-1:0] != '0) || (len_i > LEN_W'(MAX_LEN));

    // R3: a long start makes the engine busy
    a_r3_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i >= LEN_W'(LANES)) |=> busy_o);

    // R3: done is a single pulse unless a fresh short start follows
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R3: done and busy never overlap
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4: short length finishes at once with zero
    a_r4_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i < LEN_W'(LANES)) |=> (done_o && !busy_o && result_o == '0));

    // R5: flag raised for a bad length
    a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && bad_len) |=> len_err_o);

    // R5: flag cleared for a good length
    a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !bad_len) |=> !len_err_o);

    // R5: flag changes only on a start
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(len_err_o));

    // R9: idle result holds
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind dp_engine dp_engine_chk #(
    .LANES   (LANES),
    .MAX_LEN (MAX_LEN),
    .ACC_W   (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .len_i     (len_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .len_err_o (len_err_o),
    .result_o  (result_o)
);

// File: tb/dp_engine_tb.sv
`timescale 1ns/1ps
module dp_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic [10:0] len = '0;
    logic        busy, done, len_err;
    logic [41:0] result;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    dp_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start), .len_i(len),
        .busy_o(busy), .done_o(done), .len_err_o(len_err), .result_o(result)
    );

    // Behavioural reference: operand copies, pending sum and a countdown.
    int     ma [1024];
    int     mb [1024];
    bit     m_busy = 0, m_done = 0, m_err = 0;
    longint m_res = 0, m_pend = 0;
    int     m_cnt = 0;

    function automatic longint dot(input int n);
        longint s = 0;
        for (int i = 0; i < n; i++) s += longint'(ma[i]) * longint'(mb[i]);
        return s;
    endfunction

    function automatic int chunks_of(input int n);
        return (n > 1024) ? 32 : n / 32;
    endfunction

    always @(posedge clk) begin
        bit pre_busy;
        int ch;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_res = 0; m_cnt = 0;
        end else begin
            pre_busy = m_busy;
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_busy = 0; m_res = m_pend;
                end
            end
            if (wr_en && !pre_busy) begin
                if (wr_sel) mb[wr_addr] = int'($signed(wr_data));
                else        ma[wr_addr] = int'($signed(wr_data));
            end
            if (start && !pre_busy) begin
                ch = chunks_of(int'(len));
                m_err = (len > 1024) || (len % 32 != 0);
                m_res = 0;
                if (ch == 0) m_done = 1;
                else begin
                    m_busy = 1; m_cnt = ch + 7; m_pend = dot(ch * 32);
                end
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare the design with the model on every cycle.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk("R3", longint'(busy), longint'(m_busy), "busy vs model");
            chk("R3", longint'(done), longint'(m_done), "done vs model");
            chk("R5", longint'(len_err), longint'(m_err), "len_err vs model");
            if (!m_busy) chk("R2", longint'($signed(result)), m_res, "result vs model");
        end
    end

    task automatic wr(input bit sel, input int addr, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_addr = addr[9:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    task automatic run(input int n, input string tag);
        int ch; bit er; longint es; int ew; int w;
        ch = chunks_of(n);
        er = (n > 1024) || (n % 32 != 0);
        es = dot(ch * 32);
        ew = (ch == 0) ? 0 : ch + 7;
        start = 1'b1; len = n[10:0];
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 400) begin @(negedge clk); w++; end
        chk(tag, w, ew, "done latency");
        chk(tag, longint'($signed(result)), es, "result");
        chk(tag, longint'(len_err), longint'(er), "len_err");
    endtask

    initial begin : main
        longint first, held;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1: reset state
        chk("R1", longint'(busy), 0, "busy after reset");
        chk("R1", longint'(done), 0, "done after reset");
        chk("R1", longint'(len_err), 0, "len_err after reset");
        chk("R1", longint'(result), 0, "result after reset");

        for (int i = 0; i < 1024; i++) wr(1'b0, i, rnd());
        for (int i = 0; i < 1024; i++) wr(1'b1, i, rnd());

        // R2, R3: several whole-chunk lengths
        run(32, "R2");
        run(64, "R3");
        run(1024, "R2");
        run(288, "R3");
        // R4: zero and short lengths
        run(0, "R4");
        run(20, "R4");
        // R5: truncation, clamp, and clearing with a good length
        run(100, "R5");
        run(2000, "R5");
        run(64, "R5");
        // R6: repeat run gives the same sum, short after long is not accumulated
        run(96, "R6");
        first = longint'($signed(result));
        run(96, "R6");
        chk("R6", longint'($signed(result)), first, "repeat run result");
        run(1024, "R6");
        run(32, "R6");

        // R7, R8: long run with a write and a restart attempt while busy
        first = dot(1024);
        start = 1'b1; len = 11'd1024;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        wr(1'b0, 0, 16'h7FFF);
        wr(1'b1, 1, 16'h8000);
        start = 1'b1; len = 11'd32;
        @(negedge clk);
        start = 1'b0;
        w = 6;
        while (!done && w < 400) begin @(negedge clk); w++; end
        chk("R8", w, 39, "done latency with ignored start");
        chk("R8", longint'($signed(result)), first, "result with ignored start");
        @(negedge clk);
        chk("R8", longint'(done), 0, "no second done");
        run(32, "R7");

        // R9: result holds while idle
        held = longint'($signed(result));
        repeat (5) @(negedge clk);
        chk("R9", longint'($signed(result)), held, "idle hold");

        // R10: full-scale run
        for (int i = 0; i < 1024; i++) wr(1'b0, i, 16'h8000);
        for (int i = 0; i < 1024; i++) wr(1'b1, i, 16'h8000);
        run(1024, "R10");
        chk("R10", longint'($signed(result)), 64'sd1 << 40, "full-scale sum");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule